// File: doc/BRIEF.md
# Prescaled Compare Timer

A general-purpose timer built around a 24-bit up-counter. A 7-bit prescaler divides the block clock, and each prescaler tick advances the counter by one. When the counter reaches the programmed compare point, the block raises an interrupt flag and a wakeup flag. It then either wraps to zero and keeps running (periodic mode) or stops by clearing its own enable (one-shot mode).

Software drives the timer through a small synchronous register bus. Writes take effect on the clock edge, and reads are combinational from the address. The same bus gives access to the control word, the prescale divider, the compare point, a read-only view of the counter and a status word with write-1-to-clear flags. A software-reset control bit returns the prescaler, the counter and the enable to zero without disturbing the mode selection. A newly started timer waits a short fixed settling time before its first count. Two level outputs present the flags, each gated by its own enable bit.

Top module: `tmr_core`

## Requirements
- R1: After reset, control reads 0, the divider reads 0, compare reads 0xFFFFFF, the counter reads 0, status reads 0, and both `irq_o` and `wake_o` are low.
- R2: The register addresses are: 0 control, 1 divider (bits 6:0), 2 compare (bits 23:0), 3 counter (bits 23:0), 4 status. The control bits are: bit 0 run enable, bit 1 periodic (1) or one-shot (0), bit 2 interrupt output enable, bit 3 wakeup output enable, bit 4 software reset. Bit 4 is a write-only strobe and always reads 0.
- R3: While the timer runs, the counter advances once every (divider + 1) clock cycles.
- R4: A compare write stores bits 23:0 of the write data. A value below 2 is stored as 2.
- R5: In periodic mode, the prescaler tick that finds the counter at compare-1 returns the counter to 0, sets both flags, and counting continues.
- R6: In one-shot mode, that same tick returns the counter to 0, sets both flags and clears the run enable, so counting stops.
- R7: A control write that turns the enable on from off starts counting after 2 settling cycles. With divider d, the counter first reads 1 at the (d+4)-th cycle after the write edge.
- R8: While the enable is off, the counter and the prescaler hold their values.
- R9: A control write with bit 4 set clears the prescaler, the counter and the enable. The other control bits keep their previous values and the rest of that write is ignored.
- R10: Status bit 0 is the interrupt flag and bit 1 is the wakeup flag. Writing 1 to a bit clears that flag, each independently. A match in the same cycle as a clear leaves the flag set.
- R11: `irq_o` equals the interrupt flag ANDed with control bit 2. `wake_o` equals the wakeup flag ANDed with control bit 3.
- R12: Writes to the counter address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed register |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wakeup request |

## Verification
The bench measures the cycle at which a freshly enabled timer first counts. A design that skipped or lengthened the settling delay, or that miscounted the divider, would show the first count at the wrong cycle.

It also hammers the status clears across many match instants. A design that let the clear win would drop an interrupt.

The one-shot run and the software reset are checked through the control readback. A design that kept running after one period, or that lost the mode bits on reset, would read back the wrong control word.

Compare writes of 0, 1 and a value with set upper bits catch a missing clamp or a missing mask.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [2:0] {
        REG_CTRL = 3'd0,
        REG_DIV  = 3'd1,
        REG_CMP  = 3'd2,
        REG_CNT  = 3'd3,
        REG_STAT = 3'd4
    } reg_addr_e;

    localparam int CTL_EN   = 0;
    localparam int CTL_PER  = 1;
    localparam int CTL_IE   = 2;
    localparam int CTL_WE   = 3;
    localparam int CTL_SRST = 4;

    localparam int ST_INT  = 0;
    localparam int ST_WAKE = 1;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PSC_W = 7
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             clr_i,
    input  logic [PSC_W-1:0] div_i,
    output logic             tick_o
);
    logic [PSC_W-1:0] pre_d, pre_q;

    assign tick_o = run_i && (pre_q == div_i);

    always_comb begin
        pre_d = pre_q;
        if (clr_i) begin
            pre_d = '0;
        end else if (run_i) begin
            pre_d = tick_o ? '0 : pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pre_q <= '0;
        else         pre_q <= pre_d;
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             match_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign match_o = tick_i && (cnt_q == cmp_i - 1'b1);
    assign cnt_o   = cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i || match_o) begin
            cnt_d = '0;
        end else if (tick_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 24,
    parameter int PSC_W     = 7,
    parameter int CMP_MIN   = 2,
    parameter int START_DLY = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_wr_i,
    input  logic [2:0]        bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o,
    output logic              wake_o
);
    import tmr_pkg::*;

    localparam int DLY_W = $clog2(START_DLY + 2);

    typedef struct packed {
        logic             en;
        logic             per;
        logic             ie;
        logic             we;
        logic [DLY_W-1:0] dly;
        logic [PSC_W-1:0] div;
        logic [CNT_W-1:0] cmp;
        logic             intf;
        logic             wkf;
    } state_t;

    state_t st_d, st_q;

    logic             ctrl_wr, srst, run, tick;
    logic             en_w, per_w, intf_w, wkf_w, match_w;
    logic [CNT_W-1:0] cmp_w, cnt_w, cmp_in;
    logic [1:0]       clr_flags;
    reg_addr_e        addr;
    logic             unused_bits;

    assign unused_bits = ^bus_wdata_i[DATA_W-1:CNT_W];
    assign addr      = reg_addr_e'(bus_addr_i);
    assign ctrl_wr   = bus_wr_i && (addr == REG_CTRL);
    assign srst      = ctrl_wr && bus_wdata_i[CTL_SRST];
    assign run       = st_q.en && (st_q.dly == '0);
    assign cmp_in    = bus_wdata_i[CNT_W-1:0];
    assign clr_flags = (bus_wr_i && addr == REG_STAT) ?
                       {bus_wdata_i[ST_WAKE], bus_wdata_i[ST_INT]} : 2'b00;

    tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (run),
        .clr_i  (srst),
        .div_i  (st_q.div),
        .tick_o (tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick),
        .clr_i   (srst),
        .cmp_i   (st_q.cmp),
        .cnt_o   (cnt_w),
        .match_o (match_w)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.en && st_q.dly != '0) begin
            st_d.dly = st_q.dly - 1'b1;
        end
        if (match_w && !st_q.per) begin
            st_d.en = 1'b0;
        end
        if (ctrl_wr) begin
            if (srst) begin
                st_d.en  = 1'b0;
                st_d.dly = '0;
            end else begin
                st_d.en  = bus_wdata_i[CTL_EN];
                st_d.per = bus_wdata_i[CTL_PER];
                st_d.ie  = bus_wdata_i[CTL_IE];
                st_d.we  = bus_wdata_i[CTL_WE];
                if (bus_wdata_i[CTL_EN] && !st_q.en) begin
                    st_d.dly = DLY_W'(START_DLY);
                end else if (!bus_wdata_i[CTL_EN]) begin
                    st_d.dly = '0;
                end
            end
        end
        if (bus_wr_i && addr == REG_DIV) begin
            st_d.div = bus_wdata_i[PSC_W-1:0];
        end
        if (bus_wr_i && addr == REG_CMP) begin
            st_d.cmp = (cmp_in < CNT_W'(CMP_MIN)) ? CNT_W'(CMP_MIN) : cmp_in;
        end
        st_d.intf = match_w || (st_q.intf && !clr_flags[0]);
        st_d.wkf  = match_w || (st_q.wkf && !clr_flags[1]);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q     <= '0;
            st_q.cmp <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        case (addr)
            REG_CTRL: begin
                bus_rdata_o[CTL_EN]  = st_q.en;
                bus_rdata_o[CTL_PER] = st_q.per;
                bus_rdata_o[CTL_IE]  = st_q.ie;
                bus_rdata_o[CTL_WE]  = st_q.we;
            end
            REG_DIV:  bus_rdata_o[PSC_W-1:0] = st_q.div;
            REG_CMP:  bus_rdata_o[CNT_W-1:0] = st_q.cmp;
            REG_CNT:  bus_rdata_o[CNT_W-1:0] = cnt_w;
            REG_STAT: begin
                bus_rdata_o[ST_INT]  = st_q.intf;
                bus_rdata_o[ST_WAKE] = st_q.wkf;
            end
            default:  bus_rdata_o = '0;
        endcase
    end

    assign irq_o  = st_q.intf && st_q.ie;
    assign wake_o = st_q.wkf && st_q.we;

    assign en_w   = st_q.en;
    assign per_w  = st_q.per;
    assign cmp_w  = st_q.cmp;
    assign intf_w = st_q.intf;
    assign wkf_w  = st_q.wkf;
endmodule

// File: rtl/tmr_core_chk.sv
module tmr_core_chk #(
    parameter int CNT_W   = 24,
    parameter int CMP_MIN = 2
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             ctrl_wr,
    input logic             srst,
    input logic             en_w,
    input logic             per_w,
    input logic             match_w,
    input logic             intf_w,
    input logic             wkf_w,
    input logic [CNT_W-1:0] cmp_w,
    input logic [CNT_W-1:0] cnt_w
);
    assert_cmp_legal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmp_w >= CNT_W'(CMP_MIN));

    assert_periodic_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (match_w && per_w && !srst) |=> (cnt_w == '0));

    assert_oneshot_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (match_w && !per_w && !ctrl_wr) |=> !en_w);

    assert_hold_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_w && !ctrl_wr) |=> $stable(cnt_w));

    assert_soft_reset_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        srst |=> (cnt_w == '0 && !en_w && $stable(per_w)));

    assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_w |=> (intf_w && wkf_w));
endmodule

bind tmr_core tmr_core_chk #(.CNT_W(CNT_W), .CMP_MIN(CMP_MIN)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ctrl_wr (ctrl_wr),
    .srst    (srst),
    .en_w    (en_w),
    .per_w   (per_w),
    .match_w (match_w),
    .intf_w  (intf_w),
    .wkf_w   (wkf_w),
    .cmp_w   (cmp_w),
    .cnt_w   (cnt_w)
);

// File: tb/tmr_core_tb.sv
module tmr_core_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        irq, wake;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_core u_dut (
        .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq), .wake_o(wake)
    );

    // behavioural reference model
    bit m_en, m_per, m_ie, m_we, m_if, m_wf;
    int m_dly, m_pre, m_div, m_cmp, m_cnt;
    bit t_run, t_tick, t_mt, t_cw, t_sr;
    int n_pre, n_cnt, n_dly, n_div, n_cmp;
    bit n_en, n_per, n_ie, n_we, n_if, n_wf;
    logic [1:0] t_clr;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_per = 0; m_ie = 0; m_we = 0; m_if = 0; m_wf = 0;
            m_dly = 0; m_pre = 0; m_div = 0; m_cmp = 24'hFFFFFF; m_cnt = 0;
        end else begin
            t_run  = m_en && (m_dly == 0);
            t_tick = t_run && (m_pre == m_div);
            t_mt   = t_tick && (m_cnt == m_cmp - 1);
            t_cw   = wr && (addr == 3'd0);
            t_sr   = t_cw && wdata[4];
            n_pre = t_sr ? 0 : (t_run ? (t_tick ? 0 : (m_pre + 1) % 128) : m_pre);
            n_cnt = t_sr ? 0 : (t_mt ? 0 : (t_tick ? ((m_cnt + 1) & 24'hFFFFFF) : m_cnt));
            n_en = m_en; n_per = m_per; n_ie = m_ie; n_we = m_we;
            n_dly = m_dly; n_div = m_div; n_cmp = m_cmp;
            if (m_en && m_dly > 0) n_dly = m_dly - 1;
            if (t_mt && !m_per) n_en = 0;
            if (t_cw) begin
                if (t_sr) begin
                    n_en = 0; n_dly = 0;
                end else begin
                    n_en = wdata[0]; n_per = wdata[1]; n_ie = wdata[2]; n_we = wdata[3];
                    if (wdata[0] && !m_en) n_dly = 2;
                    else if (!wdata[0]) n_dly = 0;
                end
            end
            if (wr && addr == 3'd1) n_div = int'(wdata[6:0]);
            if (wr && addr == 3'd2) n_cmp = (wdata[23:0] < 24'd2) ? 2 : int'(wdata[23:0]);
            t_clr = (wr && addr == 3'd4) ? wdata[1:0] : 2'b00;
            n_if = t_mt || (m_if && !t_clr[0]);
            n_wf = t_mt || (m_wf && !t_clr[1]);
            m_en = n_en; m_per = n_per; m_ie = n_ie; m_we = n_we; m_dly = n_dly;
            m_pre = n_pre; m_cnt = n_cnt; m_div = n_div; m_cmp = n_cmp;
            m_if = n_if; m_wf = n_wf;
        end
    end

    function automatic logic [31:0] exp_rdata();
        case (addr)
            3'd0: return {28'd0, m_we, m_ie, m_per, m_en};
            3'd1: return 32'(m_div);
            3'd2: return 32'(m_cmp);
            3'd3: return 32'(m_cnt);
            3'd4: return {30'd0, m_wf, m_if};
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_cmp();
        chk("R2 R3 R5 R6 R10 model rdata", rdata, exp_rdata());
        chk("R11 model irq", {31'd0, irq}, {31'd0, m_if && m_ie});
        chk("R11 model wake", {31'd0, wake}, {31'd0, m_wf && m_we});
    endtask

    task automatic cyc(input logic w, input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        model_cmp();
        wr = w; addr = a; wdata = d;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        cyc(1'b0, a, 32'd0);
        #1 v = rdata;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        logic [31:0] v, a0;
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, v); chk("R1 ctrl", v, 32'd0);
        rd(3'd1, v); chk("R1 div", v, 32'd0);
        rd(3'd2, v); chk("R1 cmp", v, 32'hFFFFFF);
        rd(3'd3, v); chk("R1 cnt", v, 32'd0);
        rd(3'd4, v); chk("R1 stat", v, 32'd0);
        chk("R1 irq/wake", {30'd0, irq, wake}, 32'd0);

        // R4 compare clamp and mask
        cyc(1'b1, 3'd2, 32'd0);          rd(3'd2, v); chk("R4 cmp 0", v, 32'd2);
        cyc(1'b1, 3'd2, 32'd1);          rd(3'd2, v); chk("R4 cmp 1", v, 32'd2);
        cyc(1'b1, 3'd2, 32'hAB000005);   rd(3'd2, v); chk("R4 cmp mask", v, 32'd5);

        // R2 divider register
        cyc(1'b1, 3'd1, 32'hFFFFFF82);   rd(3'd1, v); chk("R2 div", v, 32'd2);

        // R3 R7 first count timing
        cyc(1'b1, 3'd2, 32'd4);
        cyc(1'b1, 3'd0, 32'h0F);
        n = 0;
        for (int i = 1; i <= 50; i++) begin
            rd(3'd3, v);
            if (v == 32'd1) begin n = i; break; end
        end
        chk("R3 R7 first count cycle", 32'(n), 32'd6);

        // R5 periodic wrap
        n = 0;
        for (int i = 0; i < 60; i++) begin
            rd(3'd3, v);
            if (irq) begin n = 1; break; end
        end
        chk("R5 irq seen", 32'(n), 32'd1);
        chk("R5 cnt at match", v, 32'd0);
        rd(3'd4, v); chk("R5 flags", v, 32'd3);

        // R10 independent clears
        cyc(1'b1, 3'd4, 32'd1);
        rd(3'd4, v); chk("R10 clear int", v, 32'd2);
        chk("R11 irq low wake high", {30'd0, irq, wake}, 32'd1);
        cyc(1'b1, 3'd4, 32'd2);
        rd(3'd4, v); chk("R10 clear wake", v, 32'd0);
        for (int i = 0; i < 40; i++) cyc(1'b1, 3'd4, 32'd3);

        // R11 gating
        cyc(1'b1, 3'd0, 32'h0B);
        for (int i = 0; i < 30; i++) cyc(1'b0, 3'd4, 32'd0);
        #1 chk("R11 stat set", rdata & 32'd1, 32'd1);
        chk("R11 irq gated", {31'd0, irq}, 32'd0);
        chk("R11 wake on", {31'd0, wake}, 32'd1);

        // R8 hold when disabled, R12 counter write ignored
        cyc(1'b1, 3'd0, 32'h02);
        rd(3'd3, a0);
        for (int i = 0; i < 7; i++) cyc(1'b0, 3'd3, 32'd0);
        rd(3'd3, v); chk("R8 hold", v, a0);
        cyc(1'b1, 3'd3, 32'h55);
        rd(3'd3, v); chk("R12 cnt write ignored", v, a0);

        // R9 soft reset keeps mode bits
        cyc(1'b1, 3'd0, 32'h0F);
        for (int i = 0; i < 10; i++) cyc(1'b0, 3'd3, 32'd0);
        cyc(1'b1, 3'd0, 32'h11);
        rd(3'd0, v); chk("R9 ctrl after srst", v, 32'h0E);
        rd(3'd3, v); chk("R9 cnt after srst", v, 32'd0);

        // R6 one-shot
        cyc(1'b1, 3'd4, 32'd3);
        cyc(1'b1, 3'd2, 32'd3);
        cyc(1'b1, 3'd1, 32'd0);
        cyc(1'b1, 3'd0, 32'h0D);
        for (int i = 0; i < 20; i++) cyc(1'b0, 3'd3, 32'd0);
        rd(3'd0, v); chk("R6 enable cleared", v, 32'h0C);
        rd(3'd3, v); chk("R6 cnt stopped", v, 32'd0);
        rd(3'd4, v); chk("R6 flags", v, 32'd3);
        for (int i = 0; i < 10; i++) cyc(1'b0, 3'd3, 32'd0);
        #1 chk("R6 still stopped", rdata, 32'd0);

        cyc(1'b0, 3'd0, 32'd0);
        done = 1;
        summary();
    end
endmodule